// File: doc/BRIEF.md
# Processor Reset Sequencer

This block orders the steps that bring a processor core out of reset and back into reset. Two request pins drive it, both active-low and both synchronised to the core clock. The hard request is a full initialisation. The controller floats the off-chip drivers and holds the core. It waits for the clock generator to report lock. It then raises a zero-fill scan enable for a fixed number of clocks. Once that scan is done and the pin is released, it sets the interrupt-prefix bit and issues the high reset vector. A checkstop recovery uses the same path. Because the clock stays locked in that case, the scan starts at once.

The soft request is a lighter event. It initialises nothing. It only raises a system reset interrupt, and the vector follows the value the prefix bit held at that moment. A soft pulse counts only if it stays low for a minimum number of clocks. The JTAG reset output follows only the JTAG reset pin, so a chip reset never reaches test logic.

The vector leaves on a valid/ready port. `vec_valid` stays high and `vec_addr` stays fixed until a cycle in which `vec_ready` is high. While one vector waits for `vec_ready`, a newly qualified soft request is dropped. A hard request clears any vector that is waiting.

Top module: `reset_sequencer`

## Requirements
- R1: From the first clock edge at which `hard_req_n` is seen low, and for as long as the hard sequence runs, `drv_hiz` is 1 and `core_run` is 0. While `hard_req_n` is low, `vec_valid` is 0.
- R2: `scan_en` first rises only after `pll_locked` has been seen high. It then stays high for exactly SCAN_CLKS (255) consecutive clocks.
- R3: If `pll_locked` is already high, `scan_en` rises within 4 clocks of `hard_req_n` falling. A hard pulse shorter than the scan still runs the full scan before the core is released.
- R4: After the scan ends and `hard_req_n` has returned high, `prefix_bit` becomes 1. Exactly one vector, 0xFFF00100, is then delivered, `core_run` goes to 1 and `drv_hiz` goes to 0.
- R5: `jtag_rst_n` is 0 while `trst_n` is 0 and returns to 1 within 2 clocks after `trst_n` rises. Neither `hard_req_n` nor anything else moves it, and `trst_n` does not stop a running core.
- R6: A soft request is accepted only if `soft_req_n` stays low for at least SOFT_MIN (2) consecutive clocks. An accepted request delivers exactly one vector, however long the pin stays low. A 1-clock pulse delivers none.
- R7: The vector for a soft request is 0x00000100 when `prefix_bit` is 0 and 0xFFF00100 when it is 1. A soft request leaves `prefix_bit` unchanged.
- R8: A soft request made while a hard sequence runs is ignored. The hard sequence delivers only its own single 0xFFF00100 vector.
- R9: While `vec_valid` is 1 and `vec_ready` is 0, `vec_valid` stays 1 and `vec_addr` stays stable. A soft request accepted during that time is dropped.
- R10: A `checkstop` seen while the core runs drives `core_run` to 0. It stays 0 until a hard sequence completes.
- R11: A clock with `ip_set_en` high loads `ip_set_val` into `prefix_bit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; bus and core clocks are treated as one |
| hard_req_n | input | 1 | Hard reset request, active low, asynchronous |
| soft_req_n | input | 1 | Soft reset request, active low, asynchronous |
| trst_n | input | 1 | JTAG reset pin, active low |
| pll_locked | input | 1 | Clock generator lock indication |
| checkstop | input | 1 | Core checkstop condition |
| ip_set_en | input | 1 | Load strobe for the prefix bit (models a software write) |
| ip_set_val | input | 1 | Value loaded into the prefix bit |
| vec_ready | input | 1 | Fetch side accepts the offered vector |
| scan_en | output | 1 | Zero-fill initialisation scan enable |
| drv_hiz | output | 1 | Tristate control for off-chip drivers |
| core_run | output | 1 | Core released and not checkstopped |
| prefix_bit | output | 1 | Current interrupt-prefix bit |
| jtag_rst_n | output | 1 | Reset to JTAG-only logic, active low |
| vec_valid | output | 1 | A reset vector is offered |
| vec_addr | output | 32 | Address of the offered reset vector |

## Verification
The two reset kinds can overlap. The bench drives the soft pin low on the same clock edge as a hard request and keeps it low over the first cycles of the hard sequence. It then counts the delivered vectors: there must be exactly one, and it must be the high address. A soft pulse can also be accepted while an earlier vector is stalled by back-pressure. The bench checks that the stalled address is delivered unchanged and that nothing follows it. A sweep over soft pulse widths and both prefix values computes each expected vector count and address from the width and the prefix.

// File: rtl/reset_seq_pkg.sv
package reset_seq_pkg;
  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_SCAN = 2'd1,
    ST_DONE = 2'd2,
    ST_RUN  = 2'd3
  } seq_state_t;

  localparam logic [31:0] VEC_HIGH = 32'hFFF0_0100;
  localparam logic [31:0] VEC_LOW  = 32'h0000_0100;
endpackage

// File: rtl/rs_sync.sv
module rs_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain <= {STAGES{RST_VAL}};
    else         chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rs_hard_fsm.sv
module rs_hard_fsm
  import reset_seq_pkg::*;
#(
  parameter int SCAN_CLKS = 255
) (
  input  logic clk,
  input  logic hard_act,
  input  logic pll_locked,
  input  logic checkstop,
  output logic scan_en,
  output logic in_run,
  output logic halted,
  output logic release_pulse
);
  localparam int CW = $clog2(SCAN_CLKS + 1);
  localparam logic [CW-1:0] LAST = CW'(SCAN_CLKS - 1);

  seq_state_t state;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    case (state)
      ST_RUN:  if (hard_act) state <= ST_WAIT;
      ST_WAIT: if (pll_locked) begin
                 state <= ST_SCAN;
                 cnt   <= '0;
               end
      ST_SCAN: begin
                 cnt <= cnt + 1'b1;
                 if (cnt == LAST) state <= ST_DONE;
               end
      ST_DONE: if (!hard_act) state <= ST_RUN;
      default: state <= ST_WAIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (hard_act)                halted <= 1'b0;
    else if (in_run && checkstop) halted <= 1'b1;
  end

  assign scan_en       = (state == ST_SCAN);
  assign in_run        = (state == ST_RUN);
  assign release_pulse = (state == ST_DONE) && !hard_act;

  // R2
  scan_after_lock_chk: assert property (@(posedge clk)
    $rose(scan_en) |-> $past(pll_locked));

  // R1
  hard_leaves_run_chk: assert property (@(posedge clk)
    hard_act |=> !in_run);
endmodule

// File: rtl/rs_soft_qual.sv
module rs_soft_qual #(
  parameter int SOFT_MIN = 2
) (
  input  logic clk,
  input  logic soft_act,
  input  logic enable,
  input  logic hard_act,
  output logic soft_take
);
  localparam int CW = $clog2(SOFT_MIN + 1);
  localparam logic [CW-1:0] HIT = CW'(SOFT_MIN - 1);
  localparam logic [CW-1:0] SAT = CW'(SOFT_MIN);

  logic [CW-1:0] run_len;

  always_ff @(posedge clk) begin
    if (!soft_act || hard_act) run_len <= '0;
    else if (run_len != SAT)   run_len <= run_len + 1'b1;
  end

  assign soft_take = soft_act && enable && !hard_act && (run_len == HIT);

  // R8
  soft_not_in_hard_chk: assert property (@(posedge clk)
    soft_take |-> !hard_act);
endmodule

// File: rtl/rs_vec_port.sv
module rs_vec_port
  import reset_seq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              hard_act,
  input  logic              release_pulse,
  input  logic              soft_take,
  input  logic              prefix,
  input  logic              vec_ready,
  output logic              vec_valid,
  output logic [ADDR_W-1:0] vec_addr
);
  always_ff @(posedge clk) begin
    if (hard_act) begin
      vec_valid <= 1'b0;
    end else if (release_pulse) begin
      vec_valid <= 1'b1;
      vec_addr  <= ADDR_W'(VEC_HIGH);
    end else if (vec_valid) begin
      if (vec_ready) vec_valid <= 1'b0;
    end else if (soft_take) begin
      vec_valid <= 1'b1;
      vec_addr  <= prefix ? ADDR_W'(VEC_HIGH) : ADDR_W'(VEC_LOW);
    end
  end

  // R9
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (hard_act)
    vec_valid && !vec_ready |=> vec_valid && $stable(vec_addr));

  // R4
  release_vector_chk: assert property (@(posedge clk) disable iff (hard_act)
    release_pulse |=> vec_valid && vec_addr == ADDR_W'(VEC_HIGH));
endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
  import reset_seq_pkg::*;
#(
  parameter int SCAN_CLKS   = 255,
  parameter int SOFT_MIN    = 2,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 32
) (
  input  logic              clk,
  input  logic              hard_req_n,
  input  logic              soft_req_n,
  input  logic              trst_n,
  input  logic              pll_locked,
  input  logic              checkstop,
  input  logic              ip_set_en,
  input  logic              ip_set_val,
  input  logic              vec_ready,
  output logic              scan_en,
  output logic              drv_hiz,
  output logic              core_run,
  output logic              prefix_bit,
  output logic              jtag_rst_n,
  output logic              vec_valid,
  output logic [ADDR_W-1:0] vec_addr
);
  logic hard_act, soft_act;
  logic in_run, halted, release_pulse, soft_take;

  rs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_hard_sync (
    .clk(clk), .arst_n(hard_req_n), .d(1'b0), .q(hard_act));

  rs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_soft_sync (
    .clk(clk), .arst_n(1'b1), .d(~soft_req_n), .q(soft_act));

  rs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_jtag_sync (
    .clk(clk), .arst_n(trst_n), .d(1'b1), .q(jtag_rst_n));

  rs_hard_fsm #(.SCAN_CLKS(SCAN_CLKS)) u_fsm (
    .clk(clk), .hard_act(hard_act), .pll_locked(pll_locked),
    .checkstop(checkstop), .scan_en(scan_en), .in_run(in_run),
    .halted(halted), .release_pulse(release_pulse));

  rs_soft_qual #(.SOFT_MIN(SOFT_MIN)) u_soft (
    .clk(clk), .soft_act(soft_act), .enable(in_run),
    .hard_act(hard_act), .soft_take(soft_take));

  always_ff @(posedge clk) begin
    if (release_pulse)  prefix_bit <= 1'b1;
    else if (ip_set_en) prefix_bit <= ip_set_val;
  end

  rs_vec_port #(.ADDR_W(ADDR_W)) u_vec (
    .clk(clk), .hard_act(hard_act), .release_pulse(release_pulse),
    .soft_take(soft_take), .prefix(prefix_bit), .vec_ready(vec_ready),
    .vec_valid(vec_valid), .vec_addr(vec_addr));

  assign drv_hiz  = hard_act || !in_run;
  assign core_run = in_run && !halted && !hard_act;

  // R7
  soft_keeps_prefix_chk: assert property (@(posedge clk) disable iff (hard_act)
    soft_take && !ip_set_en |=> $stable(prefix_bit));

  // R5
  jtag_untouched_chk: assert property (@(posedge clk) disable iff (!trst_n)
    jtag_rst_n |=> jtag_rst_n);

  // R10
  checkstop_halts_chk: assert property (@(posedge clk) disable iff (hard_act)
    checkstop && in_run |=> !core_run);
endmodule

// File: tb/reset_sequencer_test.sv
module reset_sequencer_test;
  localparam logic [31:0] HI = 32'hFFF0_0100;
  localparam logic [31:0] LO = 32'h0000_0100;

  logic clk = 1'b0;
  logic hard_req_n = 1'b0, soft_req_n = 1'b1, trst_n = 1'b0;
  logic pll_locked = 1'b0, checkstop = 1'b0;
  logic ip_set_en = 1'b0, ip_set_val = 1'b0, vec_ready = 1'b1;
  logic scan_en, drv_hiz, core_run, prefix_bit, jtag_rst_n, vec_valid;
  logic [31:0] vec_addr;

  int errors = 0, checks = 0;
  int hs_cnt = 0, scan_cycles = 0, bad_scan = 0;
  logic [31:0] last_addr = '0;

  always #5 clk = ~clk;

  reset_sequencer uut (
    .clk(clk), .hard_req_n(hard_req_n), .soft_req_n(soft_req_n),
    .trst_n(trst_n), .pll_locked(pll_locked), .checkstop(checkstop),
    .ip_set_en(ip_set_en), .ip_set_val(ip_set_val), .vec_ready(vec_ready),
    .scan_en(scan_en), .drv_hiz(drv_hiz), .core_run(core_run),
    .prefix_bit(prefix_bit), .jtag_rst_n(jtag_rst_n),
    .vec_valid(vec_valid), .vec_addr(vec_addr));

  always @(negedge clk) begin
    if (vec_valid && vec_ready) begin
      hs_cnt    <= hs_cnt + 1;
      last_addr <= vec_addr;
    end
    if (scan_en) scan_cycles <= scan_cycles + 1;
    if (scan_en && !pll_locked) bad_scan <= bad_scan + 1;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_prefix(input logic v);
    @(negedge clk);
    ip_set_en = 1'b1; ip_set_val = v;
    @(negedge clk);
    ip_set_en = 1'b0;
  endtask

  task automatic soft_pulse(input int w);
    @(negedge clk);
    soft_req_n = 1'b0;
    cyc(w);
    soft_req_n = 1'b1;
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int first;
    // power-on: hard and trst low, clock generator not yet locked
    cyc(5);
    trst_n = 1'b1;
    cyc(3);
    // R5 jtag released although hard reset still asserted
    check(jtag_rst_n == 1'b1, "R5 jtag follows trst only", 32'(jtag_rst_n), 32'd1);
    // R1 state while held
    check(drv_hiz == 1'b1, "R1 drivers float", 32'(drv_hiz), 32'd1);
    check(core_run == 1'b0, "R1 core held", 32'(core_run), 32'd0);
    check(vec_valid == 1'b0, "R1 no vector", 32'(vec_valid), 32'd0);
    cyc(12);
    check(scan_cycles == 0, "R2 no scan before lock", 32'(scan_cycles), 32'd0);
    pll_locked = 1'b1;
    cyc(300);
    check(scan_cycles == 255, "R2 scan length", 32'(scan_cycles), 32'd255);
    check(bad_scan == 0, "R2 scan only with lock", 32'(bad_scan), 32'd0);
    check(drv_hiz == 1'b1 && core_run == 1'b0, "R1 held after scan", 32'(core_run), 32'd0);
    hard_req_n = 1'b1;
    cyc(10);
    check(hs_cnt == 1, "R4 one vector", 32'(hs_cnt), 32'd1);
    check(last_addr == HI, "R4 vector address", last_addr, HI);
    check(prefix_bit == 1'b1, "R4 prefix set", 32'(prefix_bit), 32'd1);
    check(core_run == 1'b1 && drv_hiz == 1'b0, "R4 core released", 32'(core_run), 32'd1);

    // R5 trst does not disturb running core
    trst_n = 1'b0;
    cyc(2);
    check(jtag_rst_n == 1'b0, "R5 jtag reset low", 32'(jtag_rst_n), 32'd0);
    check(core_run == 1'b1, "R5 core unaffected", 32'(core_run), 32'd1);
    trst_n = 1'b1;
    cyc(3);
    check(jtag_rst_n == 1'b1, "R5 jtag reset release", 32'(jtag_rst_n), 32'd1);

    // R6 R7 R11 sweep of width and prefix
    for (int p = 0; p < 2; p++) begin
      for (int w = 1; w <= 4; w++) begin
        set_prefix(1'(p));
        check(prefix_bit == 1'(p), "R11 prefix load", 32'(prefix_bit), 32'(p));
        hs_cnt = 0;
        soft_pulse(w);
        cyc(8);
        check(hs_cnt == ((w >= 2) ? 1 : 0), "R6 soft qualification",
              32'(hs_cnt), 32'((w >= 2) ? 1 : 0));
        if (w >= 2)
          check(last_addr == (p ? HI : LO), "R7 soft vector", last_addr, p ? HI : LO);
        check(prefix_bit == 1'(p), "R7 prefix kept", 32'(prefix_bit), 32'(p));
      end
    end

    // R9 back-pressure: stall, second request dropped
    set_prefix(1'b1);
    @(negedge clk); vec_ready = 1'b0;
    hs_cnt = 0;
    soft_pulse(3);
    cyc(6);
    check(vec_valid == 1'b1 && vec_addr == HI, "R9 held under stall", vec_addr, HI);
    set_prefix(1'b0);
    soft_pulse(3);
    cyc(6);
    check(vec_valid == 1'b1 && vec_addr == HI, "R9 stable address", vec_addr, HI);
    vec_ready = 1'b1;
    cyc(6);
    check(hs_cnt == 1, "R9 single delivery", 32'(hs_cnt), 32'd1);
    check(last_addr == HI, "R9 delivered address", last_addr, HI);

    // R10 checkstop
    @(negedge clk); checkstop = 1'b1;
    @(negedge clk); checkstop = 1'b0;
    cyc(3);
    check(core_run == 1'b0, "R10 core halted", 32'(core_run), 32'd0);
    cyc(5);
    check(core_run == 1'b0, "R10 stays halted", 32'(core_run), 32'd0);

    // R3 R8 recovery: lock kept, short pulse, soft overlapping
    hs_cnt = 0; scan_cycles = 0;
    @(negedge clk);
    hard_req_n = 1'b0; soft_req_n = 1'b0;
    first = -1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (i == 5) soft_req_n = 1'b1;
      if (scan_en && first < 0) first = i + 1;
    end
    hard_req_n = 1'b1;
    check(first > 0 && first <= 4, "R3 scan without lock wait", 32'(first), 32'd4);
    cyc(300);
    check(scan_cycles == 255, "R3 full scan on short pulse", 32'(scan_cycles), 32'd255);
    check(hs_cnt == 1, "R8 soft ignored in hard", 32'(hs_cnt), 32'd1);
    check(last_addr == HI, "R8 hard vector", last_addr, HI);
    check(core_run == 1'b1, "R10 cleared by hard", 32'(core_run), 32'd1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule